// File: doc/BRIEF.md
# Burst-Aware Interrupt Moderation Unit

This unit reduces the number of host interrupts raised for completion events. It has two channels that work independently of each other, transmit (channel 0) and receive (channel 1). Each channel holds two counters. The burst counter starts at the first event of a burst and caps how long that burst may be held back. The gap counter restarts on every event and detects the quiet period that ends a burst. The channel raises its interrupt level when either counter reaches its threshold. The level stays high until the host acknowledges it. A third interrupt source, for miscellaneous causes, is not moderated and passes straight through to its output.

Software programs each counter through a small register-write port. The sequence is: write the clear bit, write the threshold, then write enable together with the chosen tick source. A counter advances either on every clock cycle or only on cycles where the external one-microsecond tick pulse is high.

Each channel is controlled by a state machine with three states: IDLE, BURST and PENDING. It has four named transitions:
- OPEN (IDLE to BURST): an event arrives while at least one of the channel's counters is enabled.
- BYPASS (IDLE to PENDING): an event arrives while neither counter is enabled.
- FIRE (BURST to PENDING): a counter has expired, or both counters have been disabled.
- RELEASE (PENDING to IDLE): the acknowledge input is high.

Top module: `irq_moderator`

## Requirements
- R1: After reset, all control and threshold registers are zero, `irq_tx` and `irq_rx` are low, and every event is therefore passed on unmoderated.
- R2: `irq_misc` follows `misc_in` in the same cycle, whatever the moderation settings are.
- R3: When both counters of a channel are disabled, an event sampled on clock edge E raises that channel's interrupt right after edge E.
- R4: Take a burst counter with threshold B > 0 and tick select 0, and let its first event be sampled on edge 0. The interrupt then rises right after edge B+1, however many further events arrive in the meantime.
- R5: Each event sampled while in BURST resets the gap counter. With threshold I > 0, let the event on edge e be followed by no event on edges e+1 through e+I. The interrupt then rises right after edge e+I+1. An event arriving on that same edge does not prevent it.
- R6: When both counters are enabled, the interrupt rises at whichever of the R4 and R5 times comes first.
- R7: With tick select 1, a counter advances only on edges where `tick_us` is high.
- R8: The interrupt is a level that stays high until `ack` is sampled high. Events arriving while it is high are absorbed: after the acknowledge, the interrupt stays low until a new event arrives.
- R9: After an acknowledge, the next event starts a new burst with both counts at zero, so R4 to R6 timing repeats exactly.
- R10: Control word bits are: bit 0 clear, bit 1 enable, bit 2 tick select. A write with bit 0 set disables the counter and zeroes its count, whatever the other bits hold. If a channel in BURST is left with both counters disabled, it takes FIRE on the next edge.
- R11: A threshold of 0 means the counter never expires. Expiry then relies on the channel's other counter alone. If both counters are enabled with threshold 0, the burst is held until reconfigured.
- R12: Register address bits are: bit 2 selects the channel (0 transmit, 1 receive), bit 1 selects the counter (0 burst, 1 gap), and bit 0 selects control (0) or threshold (1). The two channels never affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see R12) |
| wr_data | input | THR_W | Control word or threshold value |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| evt_tx | input | 1 | Transmit completion event |
| evt_rx | input | 1 | Receive event |
| ack_tx | input | 1 | Acknowledge of the transmit interrupt |
| ack_rx | input | 1 | Acknowledge of the receive interrupt |
| misc_in | input | 1 | Miscellaneous interrupt source |
| irq_tx | output | 1 | Moderated transmit interrupt level |
| irq_rx | output | 1 | Moderated receive interrupt level |
| irq_misc | output | 1 | Unmoderated miscellaneous interrupt |

## Verification
The assertions check four things on every cycle:
- a pending interrupt never drops without an acknowledge;
- an event in IDLE with moderation off always leads to the interrupt on the next cycle;
- any counter expiry seen in BURST is followed by the interrupt;
- a clear write always leaves its counter disabled.

Only the bench scenarios can show the exact rise cycle for each combination of thresholds, event spacing and tick source. The same holds for the absorbed events while pending, the independence of the two channels, and a burst held forever by two zero thresholds.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
    localparam int CTL_CLR_BIT  = 0;
    localparam int CTL_EN_BIT   = 1;
    localparam int CTL_TSEL_BIT = 2;
    localparam int NUM_CH       = 2;
    localparam int TMR_PER_CH   = 2;
    localparam int TMR_BURST    = 0;
    localparam int TMR_GAP      = 1;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_BURST   = 2'd1,
        CH_PENDING = 2'd2
    } ch_state_e;
endpackage

// File: rtl/irqmod_timer.sv
module irqmod_timer
    import irqmod_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_thr,
    input  logic [THR_W-1:0] wdata,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    output logic             enabled,
    output logic             expired
);
    logic             en_q;
    logic             tsel_q;
    logic [THR_W-1:0] thr_q;
    logic [THR_W-1:0] cnt_q;
    logic             clr_wr;
    logic             advance;

    assign clr_wr  = wr_ctl && wdata[CTL_CLR_BIT];
    assign advance = en_q && (thr_q != '0) && (tsel_q ? tick : 1'b1) && (cnt_q < thr_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            tsel_q <= 1'b0;
            thr_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ctl) begin
                if (clr_wr) begin
                    en_q   <= 1'b0;
                    tsel_q <= 1'b0;
                end else begin
                    en_q   <= wdata[CTL_EN_BIT];
                    tsel_q <= wdata[CTL_TSEL_BIT];
                end
            end
            if (wr_thr) begin
                thr_q <= wdata;
            end
            if (clr_wr || !run || restart) begin
                cnt_q <= '0;
            end else if (advance) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign enabled = en_q;
    assign expired = run && en_q && (thr_q != '0) && (cnt_q >= thr_q);

    // R10
    clear_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !enabled);
endmodule

// File: rtl/irqmod_channel.sv
module irqmod_channel
    import irqmod_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TMR_PER_CH-1:0] wr_ctl,
    input  logic [TMR_PER_CH-1:0] wr_thr,
    input  logic [THR_W-1:0]      wdata,
    input  logic                  tick,
    input  logic                  evt,
    input  logic                  ack,
    output logic                  irq
);
    ch_state_e             state_q;
    ch_state_e             state_d;
    logic                  in_burst;
    logic [TMR_PER_CH-1:0] tmr_en;
    logic [TMR_PER_CH-1:0] tmr_exp;
    logic                  moderated;
    logic                  any_exp;

    assign in_burst  = (state_q == CH_BURST);
    assign moderated = |tmr_en;
    assign any_exp   = |tmr_exp;

    for (genvar t = 0; t < TMR_PER_CH; t++) begin : g_tmr
        logic restart_t;
        if (t == TMR_GAP) begin : g_gap
            assign restart_t = evt;
        end else begin : g_cap
            assign restart_t = 1'b0;
        end
        irqmod_timer #(.THR_W(THR_W)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctl  (wr_ctl[t]),
            .wr_thr  (wr_thr[t]),
            .wdata   (wdata),
            .run     (in_burst),
            .restart (restart_t),
            .tick    (tick),
            .enabled (tmr_en[t]),
            .expired (tmr_exp[t])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (evt) begin
                    state_d = moderated ? CH_BURST : CH_PENDING;
                end
            end
            CH_BURST: begin
                if (any_exp || !moderated) begin
                    state_d = CH_PENDING;
                end
            end
            CH_PENDING: begin
                if (ack) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == CH_PENDING);
    end

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R3
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && evt && !moderated) |=> irq);

    // R6
    fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && any_exp) |=> irq);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
    import irqmod_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [THR_W-1:0] wr_data,
    input  logic             tick_us,
    input  logic             evt_tx,
    input  logic             evt_rx,
    input  logic             ack_tx,
    input  logic             ack_rx,
    input  logic             misc_in,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             irq_misc
);
    logic [NUM_CH-1:0] evt_v;
    logic [NUM_CH-1:0] ack_v;
    logic [NUM_CH-1:0] irq_v;

    assign evt_v = {evt_rx, evt_tx};
    assign ack_v = {ack_rx, ack_tx};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [TMR_PER_CH-1:0] ctl_we;
        logic [TMR_PER_CH-1:0] thr_we;
        for (genvar t = 0; t < TMR_PER_CH; t++) begin : g_dec
            logic hit;
            assign hit       = wr_en && (wr_addr[2] == c[0]) && (wr_addr[1] == t[0]);
            assign ctl_we[t] = hit && !wr_addr[0];
            assign thr_we[t] = hit && wr_addr[0];
        end
        irqmod_channel #(.THR_W(THR_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_ctl (ctl_we),
            .wr_thr (thr_we),
            .wdata  (wr_data),
            .tick   (tick_us),
            .evt    (evt_v[c]),
            .ack    (ack_v[c]),
            .irq    (irq_v[c])
        );
    end

    assign irq_tx   = irq_v[0];
    assign irq_rx   = irq_v[1];
    assign irq_misc = misc_in;
endmodule

// File: tb/test_irq_moderator.sv
module test_irq_moderator;
    localparam int CLK_P = 10;
    localparam int THR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [THR_W-1:0] wr_data = '0;
    logic             tick_us = 1'b0;
    logic [1:0]       evt = '0;
    logic [1:0]       ack = '0;
    logic             misc_in = 1'b0;
    logic             irq_tx, irq_rx, irq_misc;
    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_moderator #(.THR_W(THR_W)) i_irq_moderator (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick_us(tick_us), .evt_tx(evt[0]), .evt_rx(evt[1]), .ack_tx(ack[0]), .ack_rx(ack[1]),
        .misc_in(misc_in), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_misc(irq_misc)
    );

    function automatic logic irq_of(int ch);
        return (ch == 0) ? irq_tx : irq_rx;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data[THR_W-1:0];
        step();
        wr_en = 1'b0;
    endtask

    // R12 address: {channel, counter, thr}; R10 ctl bits: clr=0, en=1, tsel=2
    task automatic cfg(input int ch, input int t, input bit en, input bit tsel, input int thr);
        int base;
        base = ch * 4 + t * 2;
        wr(base, 1);
        wr(base + 1, thr);
        wr(base, (int'(en) << 1) | (int'(tsel) << 2));
    endtask

    task automatic do_ack(input int ch);
        ack[ch] = 1'b1;
        step();
        ack[ch] = 1'b0;
    endtask

    // drives events at iterations 0, per, 2*per ... ; returns iteration where irq seen, or -1
    task automatic measure(input int ch, input int per, input int nev, input bit tmode, output int seen);
        seen = -1;
        for (int k = 0; k < 60; k++) begin
            step();
            if (irq_of(ch)) begin
                seen = k;
                break;
            end
            evt[ch] = ((k % per) == 0) && ((k / per) < nev);
            tick_us = tmode && ((k % 4) == 1);
        end
        evt = '0;
        tick_us = 1'b0;
    endtask

    function automatic int expect_obs(int b, int gi, int per, int nev);
        int f;
        f = 1000;
        if (b > 0) f = b + 1;
        if (gi > 0) begin
            for (int j = 0; j < nev; j++) begin
                int e, nxt;
                e = j * per;
                nxt = (j + 1 < nev) ? e + per : 100000;
                if (nxt >= e + gi + 1) begin
                    if (e + gi + 1 < f) f = e + gi + 1;
                    break;
                end
            end
        end
        return (f == 1000) ? -1 : f + 1;
    endfunction

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1
        chk(!irq_tx && !irq_rx, "R1 reset irq low", int'(irq_tx) + int'(irq_rx), 0);
        measure(0, 1, 1, 1'b0, seen);
        chk(seen == 1, "R1 reset leaves tx unmoderated", seen, 1);
        do_ack(0);

        // R2
        misc_in = 1'b1; #1;
        chk(irq_misc == 1'b1, "R2 misc high", int'(irq_misc), 1);
        misc_in = 1'b0; #1;
        chk(irq_misc == 1'b0, "R2 misc low", int'(irq_misc), 0);

        // R3 both channels unmoderated
        for (int ch = 0; ch < 2; ch++) begin
            measure(ch, 2, 3, 1'b0, seen);
            chk(seen == 1, "R3 bypass timing", seen, 1);
            do_ack(ch);
            chk(!irq_of(ch), "R3 ack clears", int'(irq_of(ch)), 0);
        end

        // R4 R5 R6 R9 R11 sweep on tx, rx checked idle for R12
        for (int b = 0; b <= 5; b++) begin
            for (int gi = 0; gi <= 4; gi++) begin
                cfg(0, 0, 1'b1, 1'b0, b);
                cfg(0, 1, 1'b1, 1'b0, gi);
                for (int per = 1; per <= 4; per++) begin
                    int ex;
                    ex = expect_obs(b, gi, per, 3);
                    measure(0, per, 3, 1'b0, seen);
                    chk(seen == ex, "R4/R5/R6/R9 rise cycle", seen, ex);
                    chk(!irq_rx, "R12 rx unaffected", int'(irq_rx), 0);
                    if (ex < 0) begin
                        // R11 held forever; R10 clearing both forces fire
                        wr(0, 7);
                        wr(2, 1);
                        step();
                        chk(irq_tx, "R10 clear in burst fires", int'(irq_tx), 1);
                        cfg(0, 0, 1'b1, 1'b0, b);
                        cfg(0, 1, 1'b1, 1'b0, gi);
                    end
                    do_ack(0);
                    chk(!irq_tx, "R8 ack drops irq", int'(irq_tx), 0);
                end
            end
        end

        // R7 tick select on burst counter, gap counter off
        cfg(0, 1, 1'b0, 1'b0, 0);
        for (int b = 1; b <= 3; b++) begin
            int ex;
            cfg(0, 0, 1'b1, 1'b1, b);
            ex = 1 + 4 * (b - 1) + 2;
            measure(0, 1, 1, 1'b1, seen);
            chk(seen == ex, "R7 tick-paced rise", seen, ex);
            do_ack(0);
        end

        // R8 absorbed events
        cfg(0, 0, 1'b1, 1'b0, 2);
        measure(0, 1, 1, 1'b0, seen);
        for (int i = 0; i < 3; i++) begin
            evt[0] = 1'b1; step(); evt[0] = 1'b0; step();
        end
        chk(irq_tx, "R8 level held while pending", int'(irq_tx), 1);
        do_ack(0);
        begin
            int hi;
            hi = 0;
            for (int i = 0; i < 10; i++) begin
                step();
                if (irq_tx) hi++;
            end
            chk(hi == 0, "R8 absorbed events start no burst", hi, 0);
        end

        // R10 clear with enable bit set leaves counter off -> bypass
        wr(0, 3);
        measure(0, 1, 1, 1'b0, seen);
        chk(seen == 1, "R10 clear overrides enable", seen, 1);
        do_ack(0);

        // R12 rx moderated while tx unmoderated
        cfg(1, 0, 1'b1, 1'b0, 3);
        evt[0] = 1'b1;
        measure(1, 1, 1, 1'b0, seen);
        chk(seen == 5, "R12 rx burst timing", seen, 5);
        chk(irq_tx, "R12 tx bypass alongside", int'(irq_tx), 1);
        do_ack(1);
        do_ack(0);
        chk(!irq_tx && !irq_rx, "R12 both acked", int'(irq_tx) + int'(irq_rx), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule